// File: doc/BRIEF.md
# Opcode-Fetch ROM Automapper

This block monitors the bus of an 8-bit CPU with a separate opcode-fetch strobe and decides when the low 8 KB region should show an alternate firmware ROM in place of the main boot ROM. It watches six fixed entry points. When the CPU fetches an opcode from one of them, the block switches to the alternate ROM. Software leaves the alternate ROM again by fetching an opcode from a small window at the top of the 8 KB region.

Each entry point has its own timing class, set by a parameter. The timing class decides which bytes of the trapping instruction come from which ROM, and so which instruction actually executes:

- **Immediate.** The trapped opcode byte itself is read from the alternate ROM.
- **Refresh-deferred.** The opcode byte comes from the main ROM, and the switch happens in the refresh phase of the same fetch.
- **Next-fetch.** The switch happens when the next opcode fetch begins.

The output `map_sel` drives the ROM multiplexer. The output `mapped` is the registered paging state.

Top module: `rom_automap`

## Requirements
- R1: A synchronous active-high `rst` clears `mapped`, `map_sel` and any pending switch. After reset both outputs are low while no trap fetch is on the bus.
- R2: A trap is taken only on an opcode fetch, which is `m1_n`, `mreq_n` and `rd_n` all low. A plain memory read (`m1_n` high) or a refresh phase (`rfsh_n` and `mreq_n` low) at a trap address leaves `mapped` unchanged.
- R3: `TRAP_CLASS` holds 2 bits per trap. The traps are indexed 0 to 5 for addresses 0x0000, 0x0008, 0x0038, 0x0066, 0x04C2 and 0x0562, and trap i uses bits [2i+1:2i]. The value 0 means immediate, 1 means refresh-deferred, 2 means next-fetch, and 3 behaves like 1. The default value is 12'h040.
- R4: For an immediate trap, `map_sel` is high combinationally during the trapping fetch itself. `mapped` is high from the first clock edge of that fetch onward.
- R5: For a refresh-deferred trap, `map_sel` stays low throughout the trapping fetch. `mapped` rises at the clock edge of that same cycle's refresh phase.
- R6: With the default classes, a fetch of 0x0066 is refresh-deferred. A repeated fetch of 0x0066 while mapped sees `map_sel` high during the fetch.
- R7: For a next-fetch trap, `mapped` stays low through the trapping fetch and its refresh. `map_sel` is high during the first cycle of the next opcode fetch, and `mapped` is set by it.
- R8: With the default classes, fetches of 0x0000, 0x0008, 0x0038, 0x04C2 and 0x0562 each map immediately. Fetches of non-trap addresses (for example 0x0067) do not map.
- R9: Once set, `mapped` stays high across fetches of non-trap, non-unmap addresses until an unmap fetch or a reset.
- R10: An opcode fetch in 0x1FF8 to 0x1FFF keeps `map_sel` high during that fetch and clears `mapped` at its refresh phase. A fetch of 0x1FF7 does not unmap.
- R11: After a reset, the first fetch of 0x0000 remaps at once under the default classes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than the CPU bus cycle |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | CPU address bus |
| m1_n | input | 1 | Opcode-fetch strobe, active low |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| rfsh_n | input | 1 | Refresh strobe, active low |
| map_sel | output | 1 | High selects the alternate ROM for the low 8 KB |
| mapped | output | 1 | Registered paging state |

## Verification
The assertions assume a well-formed bus: an opcode-fetch phase and a refresh phase are never active in the same clock. They also assume each bus phase lasts at least one clock. Under that assumption, every change of the paging state can be traced to a fetch, a refresh or a reset in the cycle before. The stimulus keeps to this by driving each opcode cycle as two clocks of fetch, one idle clock, one clock of refresh and one idle clock. Plain reads and refresh-only phases are separate tasks that never overlap a fetch. All bus signals are driven on the falling clock edge.

// File: rtl/rom_automap.sv
module rom_automap #(
  parameter int          NTRAP      = 6,
  parameter logic [11:0] TRAP_CLASS = 12'h040,
  parameter logic [15:0] UNMAP_BASE = 16'h1FF8,
  parameter int          UNMAP_LSB  = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] addr,
  input  logic        m1_n,
  input  logic        mreq_n,
  input  logic        rd_n,
  input  logic        rfsh_n,
  output logic        map_sel,
  output logic        mapped
);

  localparam logic [15:0] TRAP_ADDR [NTRAP] =
    '{16'h0000, 16'h0008, 16'h0038, 16'h0066, 16'h04C2, 16'h0562};

  logic fetch, refresh;
  logic imm_hit, ref_hit, nxt_hit, unmap_hit;
  logic ref_pend, unmap_pend, nxt_pend, nxt_arm;

  assign fetch     = !m1_n && !mreq_n && !rd_n;
  assign refresh   = !rfsh_n && !mreq_n;
  assign unmap_hit = addr[15:UNMAP_LSB] == UNMAP_BASE[15:UNMAP_LSB];

  always_comb begin
    imm_hit = 1'b0;
    ref_hit = 1'b0;
    nxt_hit = 1'b0;
    for (int i = 0; i < NTRAP; i++) begin
      if (addr == TRAP_ADDR[i]) begin
        case (TRAP_CLASS[2*i +: 2])
          2'd0:    imm_hit = 1'b1;
          2'd2:    nxt_hit = 1'b1;
          default: ref_hit = 1'b1;
        endcase
      end
    end
  end

  assign map_sel = mapped || (fetch && (imm_hit || nxt_arm));

  always_ff @(posedge clk) begin
    if (rst) begin
      mapped     <= 1'b0;
      ref_pend   <= 1'b0;
      unmap_pend <= 1'b0;
      nxt_pend   <= 1'b0;
      nxt_arm    <= 1'b0;
    end else begin
      if (fetch) begin
        if (imm_hit) mapped <= 1'b1;
        if (nxt_arm) begin
          mapped  <= 1'b1;
          nxt_arm <= 1'b0;
        end
        if (ref_hit)   ref_pend   <= 1'b1;
        if (nxt_hit)   nxt_pend   <= 1'b1;
        if (unmap_hit) unmap_pend <= 1'b1;
      end
      if (refresh) begin
        if (ref_pend)   mapped <= 1'b1;
        if (unmap_pend) mapped <= 1'b0;
        ref_pend   <= 1'b0;
        unmap_pend <= 1'b0;
        if (nxt_pend) begin
          nxt_arm  <= 1'b1;
          nxt_pend <= 1'b0;
        end
      end
    end
  end

  // R4 R5 R7
  rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mapped) |-> ($past(fetch) || $past(refresh)));

  // R10
  fall_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mapped) |-> ($past(refresh) || $past(rst)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fetch && !refresh) |=> $stable(mapped));

  // R10
  sel_cover_chk: assert property (@(posedge clk) disable iff (rst)
    mapped |-> map_sel);

  // R2
  plain_read_chk: assert property (@(posedge clk) disable iff (rst)
    (m1_n && !refresh && !mapped) |=> !mapped);

endmodule

// File: tb/rom_automap_test.sv
`timescale 1ns/1ps
module rom_automap_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic m1_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1, rfsh_n = 1'b1;
  logic map_sel, mapped, map_sel2, mapped2;
  logic s_sel, s_mid, s_fin, s_sel2, s_mid2, s_fin2;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  rom_automap uut (
    .clk(clk), .rst(rst), .addr(addr), .m1_n(m1_n), .mreq_n(mreq_n),
    .rd_n(rd_n), .rfsh_n(rfsh_n), .map_sel(map_sel), .mapped(mapped));

  rom_automap #(.TRAP_CLASS(12'h048)) uut_nxt (
    .clk(clk), .rst(rst), .addr(addr), .m1_n(m1_n), .mreq_n(mreq_n),
    .rd_n(rd_n), .rfsh_n(rfsh_n), .map_sel(map_sel2), .mapped(mapped2));

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic fetch_cyc(input logic [15:0] a);
    @(negedge clk); addr = a; m1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0;
    #1 s_sel = map_sel; s_sel2 = map_sel2;
    @(negedge clk);
    @(negedge clk); m1_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1;
    #1 s_mid = mapped; s_mid2 = mapped2;
    @(negedge clk); addr = 16'h2A00; rfsh_n = 1'b0; mreq_n = 1'b0;
    @(negedge clk); rfsh_n = 1'b1; mreq_n = 1'b1;
    #1 s_fin = mapped; s_fin2 = mapped2;
  endtask

  task automatic plain_read(input logic [15:0] a);
    @(negedge clk); addr = a; mreq_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    @(negedge clk); mreq_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic refresh_only(input logic [15:0] a);
    @(negedge clk); addr = a; rfsh_n = 1'b0; mreq_n = 1'b0;
    @(negedge clk); rfsh_n = 1'b1; mreq_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 map_sel after reset", map_sel, 1'b0);
    chk("R1 mapped after reset", mapped, 1'b0);
  endtask

  task automatic t_non_fetch();
    do_reset();
    plain_read(16'h0000);
    #1 chk("R2 plain read at 0x0000", mapped, 1'b0);
    refresh_only(16'h0066);
    refresh_only(16'h0000);
    #1 chk("R2 refresh at trap address", mapped, 1'b0);
    fetch_cyc(16'h1234);
    chk("R2 non-trap fetch sel", s_sel, 1'b0);
    chk("R2 non-trap fetch mapped", s_fin, 1'b0);
  endtask

  task automatic t_immediate();
    do_reset();
    fetch_cyc(16'h0000);
    chk("R4 immediate sel during fetch", s_sel, 1'b1);
    chk("R4 immediate mapped after fetch", s_mid, 1'b1);
    chk("R11 remap at 0x0000 after reset", s_fin, 1'b1);
  endtask

  task automatic t_nmi();
    do_reset();
    fetch_cyc(16'h0066);
    chk("R5 deferred sel during fetch", s_sel, 1'b0);
    chk("R5 deferred mapped before refresh", s_mid, 1'b0);
    chk("R5 deferred mapped after refresh", s_fin, 1'b1);
    fetch_cyc(16'h0066);
    chk("R6 repeated 0x0066 sees alternate", s_sel, 1'b1);
  endtask

  task automatic t_other_traps();
    logic [15:0] list [4] = '{16'h0008, 16'h0038, 16'h04C2, 16'h0562};
    for (int i = 0; i < 4; i++) begin
      do_reset();
      fetch_cyc(list[i]);
      chk("R8 immediate default sel", s_sel, 1'b1);
      chk("R8 immediate default mapped", s_mid, 1'b1);
    end
    do_reset();
    fetch_cyc(16'h0067);
    chk("R8 near-miss 0x0067 sel", s_sel, 1'b0);
    chk("R8 near-miss 0x0067 mapped", s_fin, 1'b0);
  endtask

  task automatic t_class_param();
    do_reset();
    fetch_cyc(16'h0066);
    chk("R3 class field 3 is refresh for uut_nxt", s_sel2, 1'b0);
    chk("R3 class field 3 refresh result uut_nxt", s_fin2, 1'b1);
  endtask

  task automatic t_unmap();
    do_reset();
    fetch_cyc(16'h0038);
    fetch_cyc(16'h1234);
    fetch_cyc(16'h0100);
    chk("R9 mapped holds over normal fetches", s_fin, 1'b1);
    fetch_cyc(16'h1FF7);
    chk("R10 0x1FF7 does not unmap", s_fin, 1'b1);
    fetch_cyc(16'h1FFF);
    chk("R10 unmap fetch sel stays high", s_sel, 1'b1);
    chk("R10 unmap fetch mapped before refresh", s_mid, 1'b1);
    chk("R10 unmap cleared at refresh", s_fin, 1'b0);
    fetch_cyc(16'h0008);
    fetch_cyc(16'h1FF8);
    chk("R10 low end of window unmaps", s_fin, 1'b0);
  endtask

  task automatic t_reset_mapped();
    do_reset();
    fetch_cyc(16'h0000);
    do_reset();
    #1 chk("R1 reset clears mapped", mapped, 1'b0);
    chk("R1 reset clears map_sel", map_sel, 1'b0);
  endtask

  task automatic t_next_fetch();
    do_reset();
    fetch_cyc(16'h0008);
    chk("R7 next-fetch sel during trap", s_sel2, 1'b0);
    chk("R7 next-fetch mapped after refresh", s_fin2, 1'b0);
    fetch_cyc(16'h0009);
    chk("R7 next fetch sel high", s_sel2, 1'b1);
    chk("R7 next fetch mapped", s_mid2, 1'b1);
  endtask

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_non_fetch();
    t_immediate();
    t_nmi();
    t_other_traps();
    t_class_param();
    t_unmap();
    t_reset_mapped();
    t_next_fetch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule